// File: doc/BRIEF.md
# Reset Source Controller with Debug-Only Force Reset

This block gathers every cause that can restart the chip into a single system reset pulse and records which cause (or causes) produced the latest one. The causes arrive as single-cycle strobes: a power-on event, a low-voltage trip gated by its reset enable, an access to an unimplemented address, and a write to a force-reset register. The analog detector, the address decoder and the serial debug link stay outside; only their strobes enter here.

A small register port serves two addresses. The status address reads a byte of cause flags. The force-reset address is write-only and always reads zero. A write to it is honoured only when the port tags it as coming from the debug interface. A write from the user program is dropped without effect. Once a cause is accepted, the system reset output stays high for a fixed number of clock cycles. Any cause that arrives during that window is ignored.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is high and the status byte reads 0x02. After release, `sys_rst` stays high for at least HOLD_CYCLES and at most HOLD_CYCLES+SYNC_STAGES+2 cycles.
- R2: An unimplemented-address strobe with no power-on event starts a reset and sets status bit 3.
- R3: A low-voltage trip starts a reset and sets status bit 1 only while `lv_rst_en` is high. With the enable low, the trip has no effect.
- R4: A power-on event starts a reset and leaves the status at exactly 0x02 (bit 1 only), whatever other causes arrive in the same cycle.
- R5: A write tagged as debug (`wr_dbg`=1) to the force-reset address (`reg_sel`=1) with data bit 0 set starts a reset, and status bit 2 marks it.
- R6: A write to the force-reset address with `wr_dbg`=0 starts no reset and leaves the status unchanged.
- R7: A debug write to the force-reset address with data bit 0 clear starts no reset.
- R8: A read with `reg_sel`=1 always returns 0x00.
- R9: When several causes other than power-on are accepted in the same cycle, all of their status bits (3 illegal address, 2 debug, 1 low voltage) are set together. Bits 0 and 4 to 7 stay zero.
- R10: `sys_rst` rises in the cycle after the edge that accepts a cause and stays high for exactly HOLD_CYCLES (default 16) cycles. Causes that arrive while it is high are ignored.
- R11: The status byte changes only at the edge that accepts a cause. Writes to the status address (`reg_sel`=0) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| por_evt | input | 1 | Power-on event strobe |
| lv_trip | input | 1 | Low-voltage trip strobe |
| lv_rst_en | input | 1 | Lets a low-voltage trip cause a reset |
| bad_addr | input | 1 | Access to an unimplemented address |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 status, 1 force-reset |
| wr_dbg | input | 1 | Write comes from the debug interface |
| wr_data | input | 8 | Write data; bit 0 requests a forced reset |
| rd_data | output | 8 | Read data for the selected register |
| sys_rst | output | 1 | System reset, active high |

## Verification
A wrong cause encoding shows up in the status byte at the first read after the pulse ends. A miscounting hold timer shows up in the length of the `sys_rst` pulse, which the bench measures cycle by cycle. A gate that lets user writes through, or that fails to block causes during the hold window, shows up within one cycle: an unexpected rising edge of `sys_rst`, or a pulse of the wrong length. The sweep covers every combination of the seven cause and write inputs, so any lost or extra term in the accept logic changes at least one pulse or status byte.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned STAT_W    = 8;
  localparam int unsigned FORCE_BIT = 0;
  localparam int unsigned LV_BIT    = 1;
  localparam int unsigned DBG_BIT   = 2;
  localparam int unsigned ILL_BIT   = 3;

  localparam logic [STAT_W-1:0] STAT_AFTER_POR = STAT_W'(1 << LV_BIT);
  localparam logic [STAT_W-1:0] FORCE_MASK     = STAT_W'(1 << FORCE_BIT);

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_FORCE  = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic por;
    logic lv;
    logic dbg;
    logic ill;
  } cause_t;
endpackage

// File: rtl/rsc_rst_sync.sv
module rsc_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/rsc_regport.sv
module rsc_regport
  import rsc_pkg::*;
(
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic              wr_dbg,
  input  logic [STAT_W-1:0] wr_data,
  input  logic [STAT_W-1:0] status,
  output logic              force_req,
  output logic [STAT_W-1:0] rd_data
);
  logic sel_force;

  always_comb begin
    sel_force = (reg_sel_e'(reg_sel) == SEL_FORCE);
    // Only debug-tagged writes reach the force control; user writes vanish.
    force_req = wr_en && sel_force && wr_dbg && ((wr_data & FORCE_MASK) != '0);
    // Force register is write-only; status register is read-only.
    rd_data   = sel_force ? '0 : status;
  end
endmodule

// File: rtl/rsc_cause_merge.sv
module rsc_cause_merge
  import rsc_pkg::*;
(
  input  logic   por_evt,
  input  logic   lv_trip,
  input  logic   lv_rst_en,
  input  logic   bad_addr,
  input  logic   force_req,
  output cause_t cause,
  output logic   any_cause
);
  always_comb begin
    cause.por = por_evt;
    cause.lv  = lv_trip && lv_rst_en;
    cause.dbg = force_req;
    cause.ill = bad_addr;
    any_cause = |cause;
  end
endmodule

// File: rtl/rsc_hold_timer.sv
module rsc_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic busy
);
  localparam int unsigned CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_en;

  always_comb begin
    accept  = start && !act_q;
    tick_en = act_q || start;
    act_d   = act_q;
    cnt_d   = cnt_q;
    if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      act_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (tick_en) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign busy = act_q;
endmodule

// File: rtl/rsc_status_reg.sv
module rsc_status_reg
  import rsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  cause_t            cause,
  output logic [STAT_W-1:0] status
);
  logic [STAT_W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = '0;
    if (cause.por) begin
      stat_d = STAT_AFTER_POR;
    end else begin
      stat_d[LV_BIT]  = cause.lv;
      stat_d[DBG_BIT] = cause.dbg;
      stat_d[ILL_BIT] = cause.ill;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= STAT_AFTER_POR;
    else if (load) stat_q <= stat_d;
  end

  assign status = stat_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_evt,
  input  logic              lv_trip,
  input  logic              lv_rst_en,
  input  logic              bad_addr,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic              wr_dbg,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] rd_data,
  output logic              sys_rst
);
  logic              rst_sync_n;
  logic              force_req;
  cause_t            cause;
  logic              any_cause;
  logic              accept;
  logic              busy;
  logic [STAT_W-1:0] stat_q;

  rsc_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rsc_regport u_port (
    .wr_en     (wr_en),
    .reg_sel   (reg_sel),
    .wr_dbg    (wr_dbg),
    .wr_data   (wr_data),
    .status    (stat_q),
    .force_req (force_req),
    .rd_data   (rd_data)
  );

  rsc_cause_merge u_merge (
    .por_evt   (por_evt),
    .lv_trip   (lv_trip),
    .lv_rst_en (lv_rst_en),
    .bad_addr  (bad_addr),
    .force_req (force_req),
    .cause     (cause),
    .any_cause (any_cause)
  );

  rsc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (any_cause),
    .accept (accept),
    .busy   (busy)
  );

  rsc_status_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (accept),
    .cause  (cause),
    .status (stat_q)
  );

  assign sys_rst = busy;
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst,
  input logic       por_evt,
  input logic       lv_trip,
  input logic       lv_rst_en,
  input logic       bad_addr,
  input logic       wr_en,
  input logic       reg_sel,
  input logic       wr_dbg,
  input logic [7:0] rd_data,
  input logic [7:0] status
);
  logic [15:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= '0;
    else if (sys_rst) run_q <= run_q + 16'd1;
    else              run_q <= '0;
  end

  a_r10_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (run_q == 16'(HOLD_CYCLES)));

  a_r8_force_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (rd_data == 8'h00));

  a_r6_user_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && wr_en && reg_sel && !wr_dbg && !por_evt && !(lv_trip && lv_rst_en) && !bad_addr)
      |=> !sys_rst);

  a_r2_illegal_addr_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && bad_addr && !por_evt) |=> (sys_rst && status[3]));

  a_r4_por_only_lv_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && por_evt) |=> (status == 8'h02));

  a_r3_lv_enabled_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && lv_trip && lv_rst_en) |=> (sys_rst && status[1]));

  a_r11_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(sys_rst) |-> $stable(status));
endmodule

bind rst_src_ctrl rsc_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sys_rst   (sys_rst),
  .por_evt   (por_evt),
  .lv_trip   (lv_trip),
  .lv_rst_en (lv_rst_en),
  .bad_addr  (bad_addr),
  .wr_en     (wr_en),
  .reg_sel   (reg_sel),
  .wr_dbg    (wr_dbg),
  .rd_data   (rd_data),
  .status    (stat_q)
);

// File: tb/sim_rst_src_ctrl.sv
module sim_rst_src_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 16;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       por_evt, lv_trip, lv_rst_en, bad_addr;
  logic       wr_en, reg_sel, wr_dbg;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       sys_rst;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;
  logic [7:0] exp_stat;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_src_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .lv_trip(lv_trip),
    .lv_rst_en(lv_rst_en), .bad_addr(bad_addr), .wr_en(wr_en),
    .reg_sel(reg_sel), .wr_dbg(wr_dbg), .wr_data(wr_data),
    .rd_data(rd_data), .sys_rst(sys_rst)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic idle_in();
    por_evt = 0; lv_trip = 0; lv_rst_en = 0; bad_addr = 0;
    wr_en = 0; reg_sel = 0; wr_dbg = 0; wr_data = 8'h00;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (sys_rst === 1'b1 && n < 64) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    idle_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 sys_rst in reset", sys_rst, 1);
    chk("R1 status in reset", rd_data, 8'h02);
    rst_n = 1'b1;
    measure(n);
    chk("R1 release window", (n >= HOLD && n <= HOLD + SYNC + 2), 1);
    #1 chk("R1 status after release", rd_data, 8'h02);
    exp_stat = 8'h02;

    // Sweep all cause / write combinations.
    for (int c = 0; c < 128; c++) begin
      logic p, l, e, b, we, dg, d0, lvc, fdbg, fire;
      int ncause;
      string tag;
      p = c[0]; l = c[1]; e = c[2]; b = c[3]; we = c[4]; dg = c[5]; d0 = c[6];
      lvc  = l & e;
      fdbg = we & dg & d0;
      fire = p | lvc | b | fdbg;
      ncause = int'(lvc) + int'(b) + int'(fdbg);
      if (p)                tag = "R4 por";
      else if (ncause > 1)  tag = "R9 multi";
      else if (b)           tag = "R2 illegal";
      else if (lvc)         tag = "R3 lv enabled";
      else if (fdbg)        tag = "R5 debug force";
      else if (l)           tag = "R3 lv disabled";
      else if (we && !dg)   tag = "R6 user write";
      else if (we)          tag = "R7 debug zero";
      else                  tag = "R11 idle";

      @(negedge clk);
      por_evt = p; lv_trip = l; lv_rst_en = e; bad_addr = b;
      wr_en = we; wr_dbg = dg; reg_sel = 1'b1;
      wr_data = {7'b1010101, d0};
      @(negedge clk);
      idle_in();
      if (fire) begin
        measure(n);
        chk("R10 pulse length", n, HOLD);
        exp_stat = p ? 8'h02 : {4'b0, b, fdbg, lvc, 1'b0};
      end else begin
        chk({tag, " no reset"}, sys_rst, 0);
        @(negedge clk);
        chk({tag, " no reset later"}, sys_rst, 0);
      end
      #1 chk({tag, " status"}, rd_data, exp_stat);
      reg_sel = 1'b1;
      #1 chk("R8 force reads zero", rd_data, 8'h00);
      reg_sel = 1'b0;
    end

    // Cause during hold is ignored.
    @(negedge clk);
    bad_addr = 1'b1;
    @(negedge clk);
    bad_addr = 1'b0;
    repeat (4) @(negedge clk);
    por_evt = 1'b1; lv_trip = 1'b1; lv_rst_en = 1'b1;
    @(negedge clk);
    idle_in();
    measure(n);
    chk("R10 hold ignores causes", n, HOLD - 5);
    exp_stat = 8'h08;
    #1 chk("R10 status after ignored cause", rd_data, exp_stat);

    // Write to status address has no effect.
    @(negedge clk);
    wr_en = 1'b1; wr_dbg = 1'b1; reg_sel = 1'b0; wr_data = 8'hFF;
    @(negedge clk);
    idle_in();
    chk("R11 status write no reset", sys_rst, 0);
    #1 chk("R11 status write ignored", rd_data, exp_stat);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule